// File: doc/BRIEF.md
# Sinc Decimation Filter with Restart Sync

This block turns a 1-bit sigma-delta bit stream into signed multi-bit samples. Each input bit arrives with a one-cycle strobe. Integrators run at the bit rate. Comb stages run once per decimation period of `osrCfg` strobes, and each comb run emits one signed result. The filter order can be set to first order (sinc1) or third order (sinc3). The result is either the full-width word or a 16-bit word taken after an arithmetic right shift.

Several copies of this filter can share one external restart pulse. The pulse brings every decimation counter back to zero, so all the copies emit their results on the same strobe. In sinc3 mode the comb history needs two decimation periods to fill. The first two results after a restart, or after the filter is enabled, are therefore marked unsettled. A sticky acknowledge flag records each new result, and software clears it by writing a one. The filter runs only while both the master enable and the per-filter enable are high.

Top module: `sinc_decim_filter`

## Requirements
- R1: After reset, `result` is 0 and `newData`, `ackFlag` and `unsettled` are 0.
- R2: With `orderSel`=0 (sinc1), one result is emitted on every `osrCfg`-th strobe. The result is 2·K − OSR, where K is the number of ones among the last OSR bits. `newData` pulses in the cycle after the strobe that completes the period, and `result` holds its value between pulses.
- R3: With `orderSel`=1 (sinc3) and an input whose period divides OSR with K ones per OSR bits, every settled result is 2·K·OSR² − OSR³. At OSR 256 with all ones this gives +16777216.
- R4: Swapping the density of ones and zeros in the input gives the negated result.
- R5: With `wide16`=1, `result` is the full result shifted arithmetically right by `shiftAmt`, truncated to its low 16 bits and sign-extended.
- R6: With `syncEn`=1, a `syncPulse` sets the bit counter to zero and emits nothing in that cycle. The next result follows exactly OSR strobes after the pulse. A strobe in the same cycle as the pulse counts toward the period before the pulse.
- R7: In sinc3 mode, the first two results after a restart pulse or after the filter is enabled carry `unsettled`=1. Later results carry 0. In sinc1 mode `unsettled` is always 0.
- R8: `ackFlag` goes to 1 together with each `newData` pulse and stays at 1 until `ackClr`=1 clears it. A new result in the same cycle as a clear sets the flag.
- R9: While `masterEn` or `filtEn` is 0, no result is produced, `result` keeps its value, and the integrator and comb state is cleared.
- R10: With `syncEn`=0, `syncPulse` is ignored, and the bit counter runs freely from the moment the filter is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| masterEn | input | 1 | Global enable shared by all filters |
| filtEn | input | 1 | Enable for this filter |
| orderSel | input | 1 | 0 = sinc1, 1 = sinc3 |
| osrCfg | input | OSR_W | Oversampling ratio, 2 to 256 |
| wide16 | input | 1 | 1 = shifted 16-bit output, 0 = full width |
| shiftAmt | input | SHIFT_W | Right shift applied in 16-bit mode |
| syncEn | input | 1 | Allows `syncPulse` to restart decimation |
| syncPulse | input | 1 | External restart pulse |
| bitIn | input | 1 | Modulator bit |
| bitStb | input | 1 | Marks `bitIn` as valid for one cycle |
| ackClr | input | 1 | Write-one clear of `ackFlag` |
| result | output | ACC_W+1 | Signed filter output |
| newData | output | 1 | One-cycle pulse when `result` is updated |
| ackFlag | output | 1 | Sticky new-data acknowledge flag |
| unsettled | output | 1 | Marks the current `result` as not yet settled |

## Verification
The main path is driven with ones densities of 3/8, its complement 5/8, all ones, and densities of 3/4 and 1/4 with a period of four. The fractional densities check the sinc1 and sinc3 gains and the sign symmetry. All ones at OSR 256 reaches full scale without wrap-around error, and the period-four patterns exercise the shift and the sign extension of the 16-bit mode. A restart pulse placed three bits into a period shows whether the counter is reset and whether the unsettled marking restarts. The same pulse with the restart disabled must leave the output timing at five and thirteen bits. Streams fed with either enable low show that the enable gating works.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic {ORDER_ONE = 1'b0, ORDER_THREE = 1'b1} filtOrder_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // filter idle: wipe integrators and comb history
    logic integ;    // accept one modulator bit
    logic capture;  // store comb history (end of period or restart)
    logic emit;     // register a new output word
  } sdfStrobe_t;

  localparam int unsigned SETTLE_OUTPUTS = 2;
  localparam int unsigned SINC3_STAGES = 3;
endpackage

// File: rtl/sdf_control.sv
module sdf_control
  import sdf_pkg::*;
#(
  parameter int OSR_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             orderSel,
  input  logic [OSR_W-1:0] osrCfg,
  input  logic             syncEn,
  input  logic             syncPulse,
  input  logic             bitStb,
  input  logic             ackClr,
  output sdfStrobe_t       stb,
  output logic             newData,
  output logic             ackFlag,
  output logic             unsettled
);
  localparam int SET_W = $clog2(SETTLE_OUTPUTS + 1);
  localparam logic [OSR_W-1:0] CNT_ONE = OSR_W'(1);
  localparam logic [SET_W-1:0] SET_INIT = SET_W'(SETTLE_OUTPUTS);

  logic [OSR_W-1:0] bitCnt;
  logic [SET_W-1:0] settleCnt;
  logic syncHit;
  logic lastBit;

  assign syncHit = run & syncEn & syncPulse;
  assign lastBit = (bitCnt == osrCfg - CNT_ONE);

  always_comb begin
    stb.clear   = !run;
    stb.integ   = run & bitStb;
    stb.emit    = run & bitStb & lastBit & !syncHit;
    stb.capture = stb.emit | syncHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      settleCnt <= SET_INIT;
    end else if (!run) begin
      bitCnt    <= '0;
      settleCnt <= SET_INIT;
    end else if (syncHit) begin
      bitCnt    <= '0;
      settleCnt <= SET_INIT;
    end else if (bitStb) begin
      bitCnt <= lastBit ? '0 : bitCnt + CNT_ONE;
      if (lastBit && settleCnt != '0) settleCnt <= settleCnt - SET_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newData   <= 1'b0;
      ackFlag   <= 1'b0;
      unsettled <= 1'b0;
    end else begin
      newData <= stb.emit;
      if (stb.emit) begin
        ackFlag   <= 1'b1;
        unsettled <= (orderSel == ORDER_THREE) && (settleCnt != '0);
      end else if (ackClr) begin
        ackFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdf_datapath.sv
module sdf_datapath
  import sdf_pkg::*;
#(
  parameter int OSR_W   = 9,
  parameter int ACC_W   = 25,
  parameter int SHIFT_W = 5,
  parameter int OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  sdfStrobe_t         stb,
  input  logic               bitIn,
  input  logic               orderSel,
  input  logic [OSR_W-1:0]   osrCfg,
  input  logic               wide16,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [ACC_W:0]     result
);
  localparam int RES_W  = ACC_W + 1;
  localparam int CUBE_W = 3 * OSR_W;
  localparam int STG    = SINC3_STAGES;

  logic [STG-1:0][ACC_W-1:0] acc, accNext, combIn, combOut, dly;
  logic [ACC_W-1:0] dlyOne, oneRaw, raw;
  logic [CUBE_W-1:0] osrExt, cube;
  logic [RES_W-1:0] fullScale, twiceRaw, formatted;
  logic signed [RES_W-1:0] fullRes, shifted;

  // integrators at bit rate, each stage fed by the previous stage's new value
  assign accNext[0] = stb.integ ? acc[0] + ACC_W'(bitIn) : acc[0];
  for (genvar k = 1; k < STG; k++) begin : g_integ
    assign accNext[k] = stb.integ ? acc[k] + accNext[k-1] : acc[k];
  end

  // combs at decimated rate
  assign combIn[0] = accNext[STG-1];
  for (genvar k = 0; k < STG; k++) begin : g_comb
    assign combOut[k] = combIn[k] - dly[k];
    if (k + 1 < STG) begin : g_link
      assign combIn[k+1] = combOut[k];
    end
  end

  assign oneRaw = accNext[0] - dlyOne;
  assign raw    = (orderSel == ORDER_THREE) ? combOut[STG-1] : oneRaw;

  // signed scaling: 2*raw - full scale
  assign osrExt    = CUBE_W'(osrCfg);
  assign cube      = osrExt * osrExt * osrExt;
  assign fullScale = (orderSel == ORDER_THREE) ? cube[RES_W-1:0] : RES_W'(osrCfg);
  assign twiceRaw  = {raw, 1'b0};
  assign fullRes   = $signed(twiceRaw - fullScale);
  assign shifted   = fullRes >>> shiftAmt;
  assign formatted = wide16 ? RES_W'($signed(shifted[OUT_W-1:0])) : fullRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      dly    <= '0;
      dlyOne <= '0;
      result <= '0;
    end else if (stb.clear) begin
      acc    <= '0;
      dly    <= '0;
      dlyOne <= '0;
    end else begin
      acc <= accNext;
      if (stb.capture) begin
        dly    <= combIn;
        dlyOne <= accNext[0];
      end
      if (stb.emit) result <= formatted;
    end
  end
endmodule

// File: rtl/sinc_decim_filter.sv
module sinc_decim_filter
  import sdf_pkg::*;
#(
  parameter int OSR_W   = 9,
  parameter int ACC_W   = 25,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterEn,
  input  logic               filtEn,
  input  logic               orderSel,
  input  logic [OSR_W-1:0]   osrCfg,
  input  logic               wide16,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               syncEn,
  input  logic               syncPulse,
  input  logic               bitIn,
  input  logic               bitStb,
  input  logic               ackClr,
  output logic [ACC_W:0]     result,
  output logic               newData,
  output logic               ackFlag,
  output logic               unsettled
);
  sdfStrobe_t stb;
  logic run;

  assign run = masterEn & filtEn;

  sdf_control #(.OSR_W(OSR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .orderSel(orderSel), .osrCfg(osrCfg),
    .syncEn(syncEn), .syncPulse(syncPulse), .bitStb(bitStb), .ackClr(ackClr),
    .stb(stb), .newData(newData), .ackFlag(ackFlag), .unsettled(unsettled)
  );

  sdf_datapath #(.OSR_W(OSR_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIn(bitIn), .orderSel(orderSel),
    .osrCfg(osrCfg), .wide16(wide16), .shiftAmt(shiftAmt), .result(result)
  );
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int OSR_W   = 9,
  parameter int ACC_W   = 25,
  parameter int SHIFT_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               masterEn,
  input logic               filtEn,
  input logic               orderSel,
  input logic [OSR_W-1:0]   osrCfg,
  input logic               wide16,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic               syncEn,
  input logic               syncPulse,
  input logic               bitIn,
  input logic               bitStb,
  input logic               ackClr,
  input logic [ACC_W:0]     result,
  input logic               newData,
  input logic               ackFlag,
  input logic               unsettled
);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rstN)
    !newData |-> $stable(result));

  assert_sync_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (syncEn && syncPulse && masterEn && filtEn) |=> !newData);

  assert_sinc1_settled_R7: assert property (@(posedge clk) disable iff (!rstN)
    (newData && !$past(orderSel)) |-> !unsettled);

  assert_ack_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    newData |-> ackFlag);

  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    ackClr |=> (!ackFlag || newData));

  assert_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(masterEn && filtEn) |=> !newData);
endmodule

bind sinc_decim_filter sdf_checker #(.OSR_W(OSR_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_chk (.*);

// File: tb/sim_sinc_decim_filter.sv
`timescale 1ns/1ps
module sim_sinc_decim_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterEn = 1'b0, filtEn = 1'b0, orderSel = 1'b0, wide16 = 1'b0;
  logic [8:0] osrCfg = 9'd8;
  logic [4:0] shiftAmt = 5'd0;
  logic syncEn = 1'b0, syncPulse = 1'b0, bitIn = 1'b0, bitStb = 1'b0, ackClr = 1'b0;
  logic [25:0] result;
  logic newData, ackFlag, unsettled;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int outRes[16];
  bit outUns[16];
  int outIdx[16];
  int nOut;

  always #4 clk = ~clk;

  sinc_decim_filter u0 (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .filtEn(filtEn), .orderSel(orderSel),
    .osrCfg(osrCfg), .wide16(wide16), .shiftAmt(shiftAmt), .syncEn(syncEn),
    .syncPulse(syncPulse), .bitIn(bitIn), .bitStb(bitStb), .ackClr(ackClr),
    .result(result), .newData(newData), .ackFlag(ackFlag), .unsettled(unsettled)
  );

  task automatic checkEq(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int resVal();
    return int'($signed(result));
  endfunction

  task automatic sampleOut(input int idx);
    if (newData && nOut < 16) begin
      outRes[nOut] = resVal();
      outUns[nOut] = unsettled;
      outIdx[nOut] = idx;
      nOut++;
    end
  endtask

  // feeds n bits, one per cycle; bit j is 1 when (j mod per) < ones
  task automatic feedBits(input int n, input int per, input int ones);
    nOut = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      sampleOut(j);
      bitStb = 1'b1;
      bitIn  = ((j % per) < ones);
    end
    @(negedge clk);
    sampleOut(n);
    bitStb = 1'b0;
  endtask

  task automatic configure(input bit ord, input int osr, input bit w16, input int sh, input bit sEn);
    @(negedge clk);
    masterEn = 1'b0;
    orderSel = ord;
    osrCfg   = 9'(osr);
    wide16   = w16;
    shiftAmt = 5'(sh);
    syncEn   = sEn;
    @(negedge clk);
    masterEn = 1'b1;
    filtEn   = 1'b1;
  endtask

  task automatic pulseSync();
    @(negedge clk);
    syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
  endtask

  task automatic t_reset();
    checkEq("R1 result after reset", resVal(), 0);
    checkEq("R1 newData after reset", newData, 0);
    checkEq("R1 ackFlag after reset", ackFlag, 0);
    checkEq("R1 unsettled after reset", unsettled, 0);
  endtask

  task automatic t_sinc1();
    configure(1'b0, 8, 1'b0, 0, 1'b0);
    feedBits(16, 8, 3);
    checkEq("R2 sinc1 output count", nOut, 2);
    checkEq("R2 sinc1 first output position", outIdx[0], 8);
    checkEq("R2 sinc1 second output position", outIdx[1], 16);
    checkEq("R2 sinc1 value density 3/8", outRes[1], -2);
    checkEq("R7 sinc1 never unsettled", outUns[0], 0);
    feedBits(16, 8, 5);
    checkEq("R4 sinc1 complement value", outRes[1], 2);
  endtask

  task automatic t_sinc3();
    configure(1'b1, 8, 1'b0, 0, 1'b0);
    feedBits(24, 8, 3);
    checkEq("R3 sinc3 output count", nOut, 3);
    checkEq("R7 first after enable unsettled", outUns[0], 1);
    checkEq("R7 second after enable unsettled", outUns[1], 1);
    checkEq("R7 third after enable settled", outUns[2], 0);
    checkEq("R3 sinc3 value density 3/8", outRes[2], -128);
    feedBits(24, 8, 5);
    checkEq("R4 sinc3 complement value", outRes[2], 128);
    checkEq("R7 stays settled", outUns[0], 0);
  endtask

  task automatic t_full256();
    configure(1'b1, 256, 1'b0, 0, 1'b0);
    feedBits(768, 1, 1);
    checkEq("R3 sinc3 OSR256 output count", nOut, 3);
    checkEq("R3 sinc3 OSR256 all ones", outRes[2], 16777216);
  endtask

  task automatic t_short16();
    configure(1'b1, 256, 1'b1, 9, 1'b0);
    feedBits(768, 4, 3);
    checkEq("R5 16-bit positive", outRes[2], 16384);
    feedBits(768, 4, 1);
    checkEq("R5 16-bit negative sign-extended", outRes[2], -16384);
  endtask

  task automatic t_sync();
    configure(1'b1, 8, 1'b0, 0, 1'b1);
    feedBits(3, 1, 1);
    pulseSync();
    feedBits(24, 8, 3);
    checkEq("R6 sync output count", nOut, 3);
    checkEq("R6 first output OSR bits after sync", outIdx[0], 8);
    checkEq("R7 first after sync unsettled", outUns[0], 1);
    checkEq("R7 second after sync unsettled", outUns[1], 1);
    checkEq("R7 third after sync settled", outUns[2], 0);
    checkEq("R6 value after sync", outRes[2], -128);
  endtask

  task automatic t_nosync();
    configure(1'b0, 8, 1'b0, 0, 1'b0);
    feedBits(3, 1, 1);
    pulseSync();
    feedBits(13, 1, 1);
    checkEq("R10 ignored sync output count", nOut, 2);
    checkEq("R10 free-running first position", outIdx[0], 5);
    checkEq("R10 free-running second position", outIdx[1], 13);
  endtask

  task automatic t_ack();
    configure(1'b0, 8, 1'b0, 0, 1'b0);
    feedBits(8, 1, 1);
    checkEq("R8 ack set with output", ackFlag, 1);
    repeat (3) @(negedge clk);
    checkEq("R8 ack held", ackFlag, 1);
    ackClr = 1'b1;
    @(negedge clk);
    ackClr = 1'b0;
    checkEq("R8 ack cleared", ackFlag, 0);
  endtask

  task automatic t_enable();
    int saved;
    configure(1'b0, 8, 1'b0, 0, 1'b0);
    feedBits(8, 8, 3);
    saved = resVal();
    @(negedge clk);
    masterEn = 1'b0;
    feedBits(20, 1, 1);
    checkEq("R9 master off no output", nOut, 0);
    checkEq("R9 master off result kept", resVal(), saved);
    masterEn = 1'b1;
    filtEn = 1'b0;
    feedBits(20, 1, 1);
    checkEq("R9 filter off no output", nOut, 0);
    checkEq("R9 filter off result kept", resVal(), saved);
    filtEn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_sinc1();
    t_sinc3();
    t_full256();
    t_short16();
    t_sync();
    t_nosync();
    t_ack();
    t_enable();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule